// File: doc/BRIEF.md
# Interleaved Bank Packet Buffer Scheduler

This block is the time-slotted control and storage of a packet buffer whose storage is split across several slow banks. One clock cycle is one slot. In every slot the block can take in one fixed-size packet and hand out one packet. Each incoming packet carries a logical queue id and the absolute slot in which it must leave. A bank that starts a read or a write stays occupied for `BSLOT` slots, so back-to-back accesses must go to different banks.

Arrivals are gathered over a frame of `BSLOT` slots in an aggregation stage. During the following frame they are written, one per slot, to the lowest-numbered bank that meets three conditions: it is idle, it has a free row, and none of its stored packets has a read that would collide with this write or with this packet's own read. The read of each packet starts exactly `BSLOT` slots before its departure slot. The returned word moves through a staging line of `BSLOT` stages and appears at the output in the departure slot. Rows are handed out per bank and taken back when their read starts. If a packet finds no eligible bank, it is dropped and a sticky overflow flag is raised.

Top module: `pktbuf_sched`

## Requirements
- R1: While reset is held, and in the first slot after it, `out_valid` and `overflow` are 0. The slot count is 0 in the first cycle after reset is released and rises by one each cycle, modulo 2^`TW`.
- R2: Each accepted packet appears on `out_data`/`out_qid` with `out_valid`=1 in exactly the slot given by its `in_depart`. The bench must meet three conditions: departures are distinct, each departure is at least 3·`BSLOT` and less than 2^(`TW`-1) slots after arrival, and no more than about `NBANK`·`ROWS`/2 packets are held at once.
- R3: In every slot where no packet is due, `out_valid` is 0. This includes slots in which `in_valid` was 0.
- R4: A packet whose departure is exactly 3·`BSLOT` slots after its arrival is delivered on time, whatever its phase within the frame.
- R5: No bank is given a read or a write while a previous access to it is still within its `BSLOT` slots. A read and a write never start on the same bank in the same slot.
- R6: When a packet finds no idle bank with a free row and no read collision, it is not stored. `overflow` goes to 1 in the slot after that packet's write slot (arrival + `BSLOT`) and stays at 1 until reset.
- R7: Packets leave in departure order, not in arrival order, and the queue id is carried through unchanged. A packet that arrives later but departs earlier overtakes the packets ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet is offered in this slot |
| in_data | input | DW | Packet payload |
| in_qid | input | QW | Logical queue id |
| in_depart | input | TW | Absolute departure slot (modulo 2^TW) |
| out_valid | output | 1 | A packet leaves in this slot |
| out_data | output | DW | Departing payload |
| out_qid | output | QW | Departing queue id |
| overflow | output | 1 | Sticky: a packet was dropped for lack of an eligible bank |

## Verification
A wrong row allocation, or a row freed too early, shows up as wrong payload or queue id in the departure slot of the packets it affects. That can be up to the longest buffering delay after the fault. A fault in the frame phase, the slot count or the staging depth moves every departure, so `out_valid` pulses one or more slots early or late at the first packet. A fault in bank choice either triggers `overflow` on traffic that should fit, which is visible one slot after the write, or corrupts data when the collided read returns. The second instance, with two rows per bank, pins down the exact packet that is dropped and the exact slot in which `overflow` rises.

// File: rtl/pktbuf_sched.sv
module pktbuf_sched #(
  parameter int NBANK = 8,
  parameter int BSLOT = 2,
  parameter int ROWS  = 16,
  parameter int DW    = 16,
  parameter int QW    = 4,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [QW-1:0] in_qid,
  input  logic [TW-1:0] in_depart,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [QW-1:0] out_qid,
  output logic          overflow
);
  localparam int PW = (BSLOT > 1) ? $clog2(BSLOT) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int KW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int CW = $clog2(BSLOT + 1);
  localparam int EW = QW + DW;

  logic [TW-1:0] slot;
  logic [PW-1:0] ph;

  // aggregation (filling) and write-out frame registers
  logic [BSLOT-1:0] ivld, wvld;
  logic [EW-1:0]    iword [BSLOT];
  logic [EW-1:0]    wword [BSLOT];
  logic [TW-1:0]    idep  [BSLOT];
  logic [TW-1:0]    wdep  [BSLOT];

  // banks
  logic [EW-1:0]   mem  [NBANK][ROWS];
  logic [TW-1:0]   rdep [NBANK][ROWS];
  logic [ROWS-1:0] rvld [NBANK];
  logic [CW-1:0]   busy [NBANK];

  // staging line
  logic [BSLOT-1:0] sv;
  logic [EW-1:0]    sw [BSLOT];
  logic [TW-1:0]    sd [BSLOT];

  wire          wreq = wvld[ph];
  wire [EW-1:0] cur  = wword[ph];
  wire [TW-1:0] cdep = wdep[ph];

  logic [NBANK-1:0] ok;
  logic [RW-1:0]    frow [NBANK];
  logic [KW-1:0]    wbank;
  wire              wany  = |ok;
  wire              wfire = wreq && wany;

  always_comb begin
    for (int i = 0; i < NBANK; i++) begin
      logic [TW-1:0] d1, d2;
      logic          hasfree;
      hasfree = 1'b0;
      ok[i]   = (busy[i] == '0);
      frow[i] = '0;
      for (int j = ROWS - 1; j >= 0; j--) begin
        d1 = rdep[i][j] - TW'(BSLOT) - slot;
        d2 = rdep[i][j] - cdep + TW'(BSLOT - 1);
        if (!rvld[i][j]) begin
          hasfree = 1'b1;
          frow[i] = RW'(j);
        end else if (d1 < TW'(BSLOT) || d2 < TW'(2 * BSLOT - 1)) begin
          ok[i] = 1'b0;
        end
      end
      ok[i] = ok[i] & hasfree;
    end
    wbank = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (ok[i]) wbank = KW'(i);
  end

  logic [NBANK*ROWS-1:0] hitv;
  logic [KW-1:0]         rbank;
  logic [RW-1:0]         rrow;
  wire                   rfire = |hitv;

  always_comb begin
    rbank = '0;
    rrow  = '0;
    for (int i = 0; i < NBANK; i++)
      for (int j = 0; j < ROWS; j++) begin
        hitv[i*ROWS+j] = rvld[i][j] && ((rdep[i][j] - TW'(BSLOT)) == slot);
        if (hitv[i*ROWS+j]) begin
          rbank = KW'(i);
          rrow  = RW'(j);
        end
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot     <= '0;
      ph       <= '0;
      ivld     <= '0;
      wvld     <= '0;
      sv       <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < NBANK; i++) begin
        rvld[i] <= '0;
        busy[i] <= '0;
      end
    end else begin
      slot     <= slot + 1'b1;
      ph       <= (ph == PW'(BSLOT - 1)) ? '0 : ph + 1'b1;
      ivld[ph] <= in_valid;
      if (ph == PW'(BSLOT - 1))
        for (int k = 0; k < BSLOT; k++)
          wvld[k] <= (k == BSLOT - 1) ? in_valid : ivld[k];
      if (wreq && !wany) overflow <= 1'b1;
      sv <= {sv[BSLOT-2:0], rfire};
      if (rfire) rvld[rbank][rrow] <= 1'b0;
      if (wfire) rvld[wbank][frow[wbank]] <= 1'b1;
      for (int i = 0; i < NBANK; i++) begin
        if ((wfire && wbank == KW'(i)) || (rfire && rbank == KW'(i)))
          busy[i] <= CW'(BSLOT - 1);
        else if (busy[i] != '0)
          busy[i] <= busy[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    iword[ph] <= {in_qid, in_data};
    idep[ph]  <= in_depart;
    if (ph == PW'(BSLOT - 1))
      for (int k = 0; k < BSLOT; k++) begin
        wword[k] <= (k == BSLOT - 1) ? {in_qid, in_data} : iword[k];
        wdep[k]  <= (k == BSLOT - 1) ? in_depart : idep[k];
      end
    if (wfire) begin
      mem[wbank][frow[wbank]]  <= cur;
      rdep[wbank][frow[wbank]] <= cdep;
    end
    sw[0] <= mem[rbank][rrow];
    sd[0] <= rdep[rbank][rrow];
    for (int k = 1; k < BSLOT; k++) begin
      sw[k] <= sw[k-1];
      sd[k] <= sd[k-1];
    end
  end

  assign out_valid = sv[BSLOT-1];
  assign {out_qid, out_data} = sw[BSLOT-1];

  a_r5_read_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rfire |-> (busy[rbank] == '0) && !(wfire && wbank == rbank));

  a_r5_write_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wfire |-> !(rfire && rbank == wbank));

  a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));

  a_r2_depart_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sd[BSLOT-1] == slot);

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: tb/pktbuf_sched_tb.sv
`timescale 1ns/1ps
module pktbuf_sched_tb;
  localparam int DW = 16, QW = 4, TW = 8, B = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [QW-1:0] in_qid = '0;
  logic [TW-1:0] in_depart = '0;
  logic          out_valid, overflow;
  logic [DW-1:0] out_data;
  logic [QW-1:0] out_qid;

  logic          s_in_valid = 1'b0;
  logic [TW-1:0] s_in_depart = '0;
  logic          s_out_valid, s_overflow;
  logic [DW-1:0] s_out_data;
  logic [QW-1:0] s_out_qid;

  pktbuf_sched u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_qid(in_qid), .in_depart(in_depart), .out_valid(out_valid),
    .out_data(out_data), .out_qid(out_qid), .overflow(overflow));

  pktbuf_sched #(.ROWS(2)) u_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_data(16'h5A5A),
    .in_qid(4'h3), .in_depart(s_in_depart), .out_valid(s_out_valid),
    .out_data(s_out_data), .out_qid(s_out_qid), .overflow(s_overflow));

  int ntest = 0, nfail = 0, tslot = 0, scount = 0;
  bit done = 1'b0;

  int            qd[$];
  logic [DW-1:0] qdat[$];
  logic [QW-1:0] qq[$];
  string         qr[$];

  always @(posedge clk) if (rst_n) tslot <= tslot + 1;
  always @(negedge clk) if (rst_n && s_out_valid) scount <= scount + 1;

  // reference: a packet is due exactly in its departure slot
  always @(negedge clk) begin
    int hit;
    if (rst_n && !done) begin
      hit = -1;
      foreach (qd[i]) if (qd[i] == tslot) hit = i;
      ntest++;
      if (hit >= 0) begin
        if (!(out_valid === 1'b1 && out_data === qdat[hit] && out_qid === qq[hit])) begin
          nfail++;
          $display("FAIL %s slot %0d: got v=%b d=%h q=%h, expected v=1 d=%h q=%h",
                   qr[hit], tslot, out_valid, out_data, out_qid, qdat[hit], qq[hit]);
        end
        qd.delete(hit); qdat.delete(hit); qq.delete(hit); qr.delete(hit);
      end else if (out_valid !== 1'b0) begin
        nfail++;
        $display("FAIL R3 slot %0d: got v=%b, expected v=0", tslot, out_valid);
      end
      ntest++;
      if (overflow !== 1'b0) begin
        nfail++;
        $display("FAIL R6 slot %0d: got overflow=%b, expected 0", tslot, overflow);
      end
    end
  end

  task automatic check(string req, logic got, logic exp);
    ntest++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s slot %0d: got %b, expected %b", req, tslot, got, exp);
    end
  endtask

  task automatic send(logic [DW-1:0] d, logic [QW-1:0] q, int delay, string req);
    in_valid  = 1'b1;
    in_data   = d;
    in_qid    = q;
    in_depart = TW'(tslot + delay);
    qd.push_back(tslot + delay); qdat.push_back(d); qq.push_back(q); qr.push_back(req);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    check("R1", out_valid, 1'b0);
    check("R1", overflow, 1'b0);
    check("R1", s_overflow, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid, 1'b0);

    // continuous stream, fixed delay (R2 R5)
    for (int k = 0; k < 20; k++) send(16'hA000 + 16'(k), QW'(k), 10, "R2 R5");
    idle(16);

    // later arrivals depart earlier (R7)
    for (int j = 0; j < 6; j++) send(16'hB000 + 16'(j), QW'(15 - j), 20 - 2 * j, "R7");
    idle(20);

    // minimum delay in both frame phases (R4)
    send(16'hC001, 4'h1, 3 * B, "R4");
    send(16'hC002, 4'h2, 3 * B, "R4");
    idle(1);
    send(16'hC003, 4'h3, 3 * B, "R4");
    idle(10);

    // sparse arrivals with gaps (R2 R3)
    for (int k = 0; k < 10; k++) begin
      send(16'hD000 + 16'(k), QW'(k + 5), 6 + (k % 2), "R3");
      idle(1);
    end
    idle(12);

    // long delay overtaken by short ones (R7)
    send(16'hE0FF, 4'hE, 100, "R7");
    for (int k = 0; k < 8; k++) send(16'hE000 + 16'(k), QW'(k), 8 + k, "R7");
    idle(110);
    ntest++;
    if (qd.size() != 0) begin
      nfail++;
      $display("FAIL R2: got %0d undelivered packets, expected 0", qd.size());
    end

    // overflow on the two-row instance (R6)
    a0 = tslot;
    for (int k = 0; k < 17; k++) begin
      s_in_valid  = 1'b1;
      s_in_depart = TW'(tslot + 60);
      @(negedge clk);
    end
    s_in_valid = 1'b0;
    check("R6", s_overflow, 1'b0);           // tslot = a0+17
    @(negedge clk);
    check("R6", s_overflow, 1'b0);           // a0+18: write slot of packet 16
    @(negedge clk);
    check("R6", s_overflow, 1'b1);           // a0+19
    idle(80);
    check("R6", s_overflow, 1'b1);
    ntest++;
    if (scount != 16) begin
      nfail++;
      $display("FAIL R6: got %0d delivered from small buffer, expected 16 (start %0d)", scount, a0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule